// File: doc/BRIEF.md
# Register Logic Micro-operation Unit

This block holds an accumulator register and applies one bitwise micro-operation to it each time a start strobe arrives. The operation takes the accumulator and an operand word. A 3-bit op code selects the operation: load, selective set, selective complement, selective clear, mask, a two-step field insert, compare, or no-op. The updated accumulator, a one-cycle done pulse and an equality flag are registered outputs.

Most operations finish at the clock edge that samples the strobe. Insert is a sequence of two steps. At the first edge the accumulator is ANDed with the operand, which acts as a mask that clears the target field. At the second edge the accumulator is ORed with a new field value, which is captured when the strobe is sampled. Compare writes the XOR of accumulator and operand back into the accumulator. It also raises the equality flag when that XOR is all zeros, so the flag shows whether the two words were equal.

Top module: `logic_uop_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, acc_o is 0, done_o is 0 and eq_o is 0.
- R2: op_i = 0 (load) with start_i writes opnd_i into the accumulator at the sampling edge.
- R3: op_i = 1 (selective set) writes A OR B: each bit of A where B is 1 becomes 1, and the other bits stay unchanged.
- R4: op_i = 2 (selective complement) writes A XOR B: each bit of A where B is 1 is inverted.
- R5: op_i = 3 (selective clear) writes A AND NOT B: each bit of A where B is 1 becomes 0.
- R6: op_i = 4 (mask) writes A AND B: each bit of A where B is 0 becomes 0.
- R7: op_i = 5 (insert): at the sampling edge A becomes A AND B. At the next edge A becomes that value OR V, where V is ins_val_i as sampled with the strobe. done_o is 0 after the first edge and 1 after the second. Example: A=0x6A, B=0x0F, V=0x90 gives 0x9A.
- R8: A start_i that is high in the cycle after an insert was accepted is ignored. The insert result is unchanged and no extra done pulse follows.
- R9: op_i = 6 (compare) writes A XOR B. eq_o becomes 1 if the old A equalled B and 0 otherwise, and eq_o keeps that value until the next compare.
- R10: op_i = 7 (no-op) leaves A unchanged and still produces a done pulse.
- R11: done_o is 1 for exactly the cycle after the edge that completes an operation. With no start_i and no insert in progress, done_o goes to 0 and acc_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, sampled at the rising edge |
| op_i | input | 3 | Operation code (see R2 to R10) |
| opnd_i | input | 8 | Operand word B; the mask for insert |
| ins_val_i | input | 8 | New field value for insert |
| acc_o | output | 8 | Accumulator A |
| done_o | output | 1 | One-cycle completion pulse |
| eq_o | output | 1 | Equality flag from the last compare |

## Verification
On every cycle the assertions check the following: the one-step results of set and compare against the previous accumulator and operand, the equality flag after a compare, that the second insert step always follows the first with a done pulse, and that the accumulator is quiet and done_o is low while the unit is idle. The bench scenarios cover the rest. They check the full two-step insert value, including the worked example. They show that a strobe arriving during an insert is ignored. They confirm that the flag holds across other operations, and they run long random sequences of all eight op codes against a model of the accumulator.

// File: rtl/logic_uop_pkg.sv
package logic_uop_pkg;
  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_SET  = 3'd1,
    OP_CPL  = 3'd2,
    OP_CLR  = 3'd3,
    OP_MASK = 3'd4,
    OP_INS  = 3'd5,
    OP_CMP  = 3'd6,
    OP_NOP  = 3'd7
  } uop_e;
endpackage

// File: rtl/logic_uop_alu.sv
module logic_uop_alu
  import logic_uop_pkg::*;
#(
  parameter int W = 8
) (
  input  uop_e         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  // One bit slice per accumulator bit; insert step one behaves as mask.
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      case (op)
        OP_LOAD:         res[i] = b[i];
        OP_SET:          res[i] = a[i] | b[i];
        OP_CPL, OP_CMP:  res[i] = a[i] ^ b[i];
        OP_CLR:          res[i] = a[i] & ~b[i];
        OP_MASK, OP_INS: res[i] = a[i] & b[i];
        default:         res[i] = a[i];
      endcase
    end
  end
endmodule

// File: rtl/logic_uop_seq.sv
module logic_uop_seq (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic is_ins,
  output logic accept,
  output logic busy,
  output logic done
);
  // A strobe is taken only when no insert is in its second step.
  assign accept = start & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      busy <= accept & is_ins;
      done <= (accept & ~is_ins) | busy;
    end
  end
endmodule

// File: rtl/logic_uop_unit.sv
module logic_uop_unit
  import logic_uop_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] opnd_i,
  input  logic [W-1:0] ins_val_i,
  output logic [W-1:0] acc_o,
  output logic         done_o,
  output logic         eq_o
);
  localparam logic [W-1:0] ZERO = '0;

  uop_e         op;
  logic         accept;
  logic         busy;
  logic [W-1:0] alu_res;
  logic [W-1:0] acc_q;
  logic [W-1:0] field_q;
  logic         eq_q;

  assign op = uop_e'(op_i);

  logic_uop_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start_i),
    .is_ins(op == OP_INS),
    .accept(accept),
    .busy  (busy),
    .done  (done_o)
  );

  logic_uop_alu #(.W(W)) u_alu (
    .op (op),
    .a  (acc_q),
    .b  (opnd_i),
    .res(alu_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= ZERO;
      field_q <= ZERO;
      eq_q    <= 1'b0;
    end else begin
      if (accept) begin
        acc_q <= alu_res;
        if (op == OP_INS) field_q <= ins_val_i;
        if (op == OP_CMP) eq_q <= (alu_res == ZERO);
      end else if (busy) begin
        acc_q <= acc_q | field_q;
      end
    end
  end

  assign acc_o = acc_q;
  assign eq_o  = eq_q;
endmodule

// File: rtl/logic_uop_unit_chk.sv
module logic_uop_unit_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] opnd_i,
  input logic [W-1:0] acc_o,
  input logic         done_o,
  input logic         eq_o,
  input logic         busy
);
  // R3: selective set result one edge after the strobe
  a_r3_set_result: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy && op_i == 3'd1) |=> acc_o == ($past(acc_o) | $past(opnd_i)));

  // R9: compare writes the XOR back and sets the flag from equality
  a_r9_compare_flag: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy && op_i == 3'd6) |=>
      (eq_o == ($past(acc_o) == $past(opnd_i))) && (acc_o == ($past(acc_o) ^ $past(opnd_i))));

  // R7: the first insert step is followed by the second and a done pulse
  a_r7_insert_second_step: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy && op_i == 3'd5) |=> !done_o ##1 done_o);

  // R8: a strobe during the second step is ignored
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy && done_o);

  // R11: idle cycles give no pulse and keep the accumulator
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !busy) |=> !done_o && $stable(acc_o));

  // R10: the no-op keeps the accumulator and pulses done
  a_r10_nop: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy && op_i == 3'd7) |=> done_o && $stable(acc_o));
endmodule

bind logic_uop_unit logic_uop_unit_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start_i(start_i),
  .op_i   (op_i),
  .opnd_i (opnd_i),
  .acc_o  (acc_o),
  .done_o (done_o),
  .eq_o   (eq_o),
  .busy   (busy)
);

// File: tb/logic_uop_unit_bench.sv
module logic_uop_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         start_i;
  logic [2:0]   op_i;
  logic [W-1:0] opnd_i;
  logic [W-1:0] ins_val_i;
  logic [W-1:0] acc_o;
  logic         done_o;
  logic         eq_o;

  int total = 0;
  int bad = 0;
  logic [W-1:0] m_acc;
  logic         m_eq;
  bit           finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic_uop_unit #(.W(W)) u_logic_uop_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .opnd_i(opnd_i),
    .ins_val_i(ins_val_i), .acc_o(acc_o), .done_o(done_o), .eq_o(eq_o)
  );

  function automatic logic [W-1:0] model(input logic [2:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    case (op)
      3'd0: return b;
      3'd1: return a | b;
      3'd2: return a ^ b;
      3'd3: return a & ~b;
      3'd4: return a & b;
      3'd5: return a & b;
      3'd6: return a ^ b;
      default: return a;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  // Inputs change at the falling edge; results are read at the next falling edge.
  task automatic run_op(input logic [2:0] op, input logic [W-1:0] b, input logic [W-1:0] v,
                        input bit poke);
    logic [W-1:0] step1;
    start_i = 1'b1; op_i = op; opnd_i = b; ins_val_i = v;
    step1 = model(op, m_acc, b);
    if (op == 3'd6) m_eq = (m_acc == b);
    @(negedge clk);
    if (op == 3'd5) begin
      check("R7 step one", acc_o, step1);
      check("R7 no early done", {7'd0, done_o}, 8'd0);
      if (poke) begin
        start_i = 1'b1; op_i = 3'd0; opnd_i = ~b; ins_val_i = ~v;
      end else start_i = 1'b0;
      m_acc = step1 | v;
      @(negedge clk);
      check(poke ? "R8 insert result kept" : "R7 insert result", acc_o, m_acc);
      check("R7 done after step two", {7'd0, done_o}, 8'd1);
    end else begin
      m_acc = step1;
      check(req_of(op), acc_o, m_acc);
      check("R11 done pulse", {7'd0, done_o}, 8'd1);
    end
    check("R9 flag", {7'd0, eq_o}, {7'd0, m_eq});
    start_i = 1'b0;
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    check(req, {7'd0, done_o}, 8'd0);
    check(req, acc_o, m_acc);
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; start_i = 1'b0; op_i = '0; opnd_i = '0; ins_val_i = '0;
    m_acc = '0; m_eq = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 acc reset", acc_o, 8'h00);
    check("R1 done reset", {7'd0, done_o}, 8'd0);
    check("R1 eq reset", {7'd0, eq_o}, 8'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", acc_o, 8'h00);

    // Directed cases
    run_op(3'd0, 8'h6A, 8'h00, 0);          // R2 load
    run_op(3'd5, 8'h0F, 8'h90, 0);          // R7 worked example
    check("R7 example value", acc_o, 8'h9A);
    idle_check("R11 idle after insert");
    run_op(3'd0, 8'hA0, 8'h00, 0);
    run_op(3'd1, 8'h0C, 8'h00, 0);          // R3 -> AC
    check("R3 set value", acc_o, 8'hAC);
    run_op(3'd2, 8'hFF, 8'h00, 0);          // R4 -> 53
    run_op(3'd3, 8'h03, 8'h00, 0);          // R5 -> 50
    run_op(3'd4, 8'hF0, 8'h00, 0);          // R6 -> 50
    run_op(3'd6, 8'h50, 8'h00, 0);          // R9 equal
    check("R9 equal flag", {7'd0, eq_o}, 8'd1);
    check("R9 xor written", acc_o, 8'h00);
    run_op(3'd7, 8'h55, 8'h00, 0);          // R10 no-op
    check("R9 flag held", {7'd0, eq_o}, 8'd1);
    run_op(3'd6, 8'h01, 8'h00, 0);          // R9 unequal
    check("R9 unequal flag", {7'd0, eq_o}, 8'd0);
    run_op(3'd5, 8'hF0, 8'h0A, 1);          // R8 strobe during insert
    idle_check("R8 no extra done");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      logic [W-1:0] b;
      op = 3'($urandom_range(0, 7));
      b = 8'($urandom);
      if (op == 3'd6 && $urandom_range(0, 3) == 0) b = m_acc;
      run_op(op, b, 8'($urandom), bit'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) idle_check("R11 random idle");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule